// File: doc/BRIEF.md
# Double-Buffered Bank-Switched Framebuffer

This block holds two equal pixel memories (banks) of one byte per pixel. At any time one bank is scanned out to the display and the other accepts writes from the host, so reads and writes never compete for a bank. A single bank-select flip-flop assigns the two roles. When the host has finished a complete frame in its writable bank, it raises a swap request. The request is held as pending and applied at the next start of vertical blanking. The new frame then becomes visible in one step, with no tearing, and the old display bank becomes writable.

The display side gives a row/column scan position and receives the pixel one clock later. The host side is a plain write port that takes a write on every clock, with no stall. The bank geometry is set by parameters. A 256 x 256 build uses 8 + 8 index bits, which gives a 16-bit address. The default build is smaller.

Top module: `dbuf_fb_top`

## Requirements
- R1: After reset the display reads bank A (`dispBank` = 0), bank B is writable, and `swapPending` is 0.
- R2: A host write (`hostWe` = 1) stores `hostData` at `hostAddr` in the bank that is not displayed, in the same clock cycle. Writes can be issued on consecutive cycles with no stall.
- R3: A host write never changes any pixel of the bank that is currently displayed.
- R4: `pixOut` presents the byte stored at address {`scanY`,`scanX`} (row-major: row index in the upper bits) of the displayed bank. It is valid one clock after the scan position is applied.
- R5: A one-cycle `swapReq` sets `swapPending` on the next clock. The displayed bank does not change before a rising edge of `vblank`.
- R6: In the cycle where `vblank` is first seen high with the swap pending, `dispBank` toggles and `swapPending` clears. Further requests made while a swap is pending still give only one swap.
- R7: A `swapReq` made in the very cycle that performs a swap is kept as pending and takes effect at the following vertical-blank start.
- R8: A rising edge of `vblank` with no swap pending leaves `dispBank` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | Y_BITS+X_BITS | Host pixel address, row-major |
| hostData | input | PIX_W | Host pixel byte |
| swapReq | input | 1 | Request to exchange the bank roles |
| vblank | input | 1 | Vertical blanking level from the timing generator |
| scanX | input | X_BITS | Display column |
| scanY | input | Y_BITS | Display row |
| pixOut | output | PIX_W | Displayed pixel, one cycle after the scan position |
| dispBank | output | 1 | Bank currently displayed (0 = A, 1 = B) |
| swapPending | output | 1 | A swap has been requested but not yet applied |

## Verification
The bench attacks the timing of the swap. It holds a request across many cycles with `vblank` low and checks that the image stays the same. A design that swapped at once would tear the frame and clear `swapPending` too early. Writes made during display are checked against the full contents of the visible bank. A design that routed the write enable from the wrong side of the selector would corrupt the visible image. Repeated requests and a request made in the very cycle of a swap are also driven: a design that toggled once per request would show the wrong bank, and one that dropped the coincident request would never reach the next frame. A vertical blank with nothing pending checks that the selector does not move on its own.

// File: rtl/dbuf_fb_pkg.sv
package dbuf_fb_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic [1:0] wrEn;   // per-bank write enable
    logic       rdSel;  // bank feeding the display
  } fbStrobe_t;
endpackage

// File: rtl/dbuf_fb_ctrl.sv
module dbuf_fb_ctrl
  import dbuf_fb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostWe,
  input  logic      swapReq,
  input  logic      vblank,
  output fbStrobe_t strobe,
  output logic      dispSel,
  output logic      pending
);
  logic vblankQ;
  logic vblankRise;
  logic doSwap;

  assign vblankRise = vblank && !vblankQ;
  assign doSwap     = vblankRise && pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vblankQ <= 1'b0;
      dispSel <= 1'b0;
      pending <= 1'b0;
    end else begin
      vblankQ <= vblank;
      if (doSwap) begin
        dispSel <= ~dispSel;
        pending <= swapReq;
      end else if (swapReq) begin
        pending <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.rdSel   = dispSel;
    strobe.wrEn[0] = hostWe && dispSel;
    strobe.wrEn[1] = hostWe && !dispSel;
  end

  // R5: a request is always pending on the following cycle
  p_req_pends_r5: assert property (@(posedge clk) disable iff (!rstN)
    swapReq |=> pending);

  // R6/R8: the selector moves only at a vertical-blank start with a pending swap
  p_swap_at_vblank_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dispSel != $past(dispSel)) |-> ($past(vblank) && !$past(vblankQ) && $past(pending)));

  // R8: no pending swap means the selector holds
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && !swapReq) |=> $stable(dispSel));
endmodule

// File: rtl/dbuf_fb_datapath.sv
module dbuf_fb_datapath
  import dbuf_fb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PIX_W-1:0]  pixOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [PIX_W-1:0] rdData [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [PIX_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (strobe.wrEn[b]) mem[wrAddr] <= wrData;
    end
    assign rdData[b] = mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixOut <= '0;
    else       pixOut <= rdData[strobe.rdSel];
  end

  // R3: the displayed bank never receives a write enable
  p_no_write_shown_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn[strobe.rdSel]);

  // R2: at most one bank written per cycle
  p_one_bank_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wrEn));
endmodule

// File: rtl/dbuf_fb_top.sv
module dbuf_fb_top
  import dbuf_fb_pkg::*;
#(
  parameter int X_BITS = 5,
  parameter int Y_BITS = 5,
  parameter int PIX_W  = 8,
  localparam int ADDR_W = X_BITS + Y_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [PIX_W-1:0]  hostData,
  input  logic              swapReq,
  input  logic              vblank,
  input  logic [X_BITS-1:0] scanX,
  input  logic [Y_BITS-1:0] scanY,
  output logic [PIX_W-1:0]  pixOut,
  output logic              dispBank,
  output logic              swapPending
);
  fbStrobe_t strobe;

  dbuf_fb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostWe  (hostWe),
    .swapReq (swapReq),
    .vblank  (vblank),
    .strobe  (strobe),
    .dispSel (dispBank),
    .pending (swapPending)
  );

  dbuf_fb_datapath #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (hostAddr),
    .wrData (hostData),
    .rdAddr ({scanY, scanX}),
    .pixOut (pixOut)
  );

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    $past(!rstN) |-> (!dispBank && !swapPending));
endmodule

// File: tb/dbuf_fb_top_tb.sv
module dbuf_fb_top_tb;
  localparam int XB = 5;
  localparam int YB = 5;
  localparam int AW = XB + YB;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostWe = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [7:0]    hostData = '0;
  logic          swapReq = 1'b0;
  logic          vblank = 1'b0;
  logic [XB-1:0] scanX = '0;
  logic [YB-1:0] scanY = '0;
  logic [7:0]    pixOut;
  logic          dispBank;
  logic          swapPending;

  int checks = 0;
  int errors = 0;
  logic [7:0] modelA [N];
  logic [7:0] modelB [N];
  logic       modelSel = 1'b0;

  always #10 clk = ~clk;

  dbuf_fb_top #(.X_BITS(XB), .Y_BITS(YB), .PIX_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostData(hostData), .swapReq(swapReq), .vblank(vblank),
    .scanX(scanX), .scanY(scanY), .pixOut(pixOut),
    .dispBank(dispBank), .swapPending(swapPending)
  );

  function automatic logic [7:0] pat(int a, int k);
    return 8'((a * 7 + k * 37 + (a >> 3)) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write pixels [lo,hi) with pattern k to the writable bank, one per cycle
  task automatic hostFill(int lo, int hi, int k);
    for (int a = lo; a < hi; a++) begin
      @(negedge clk);
      hostWe = 1'b1; hostAddr = AW'(a); hostData = pat(a, k);
      if (modelSel) modelA[a] = pat(a, k); else modelB[a] = pat(a, k);
    end
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk); swapReq = 1'b1;
    @(negedge clk); swapReq = 1'b0;
  endtask

  task automatic vblankPulse();
    @(negedge clk); vblank = 1'b1;
    if (swapPending) modelSel = ~modelSel;
    repeat (3) @(negedge clk);
    vblank = 1'b0;
  endtask

  // compare the whole displayed frame to the model of the bank that should show
  task automatic checkFrame(string req);
    int bad = 0;
    int badA = 0;
    int badAct = 0;
    int badExp = 0;
    for (int a = 0; a < N; a++) begin
      logic [7:0] e;
      @(negedge clk);
      {scanY, scanX} = AW'(a);
      @(negedge clk);
      e = modelSel ? modelB[a] : modelA[a];
      if (pixOut !== e && bad == 0) begin
        badA = a; badAct = int'(pixOut); badExp = int'(e);
      end
      if (pixOut !== e) bad++;
    end
    if (bad != 0) $display("FAIL %s: pixel %0d actual %0d expected %0d", req, badA, badAct, badExp);
    chk(req, bad, 0);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 dispBank", int'(dispBank), 0);
    chk("R1 swapPending", int'(swapPending), 0);
  endtask

  task automatic tFirstSwap();
    hostFill(0, N, 1);            // R2 back-to-back writes to bank B
    pulseReq();
    chk("R5 pending set", int'(swapPending), 1);
    repeat (20) @(negedge clk);
    chk("R5 no swap before vblank", int'(dispBank), 0);
    vblankPulse();
    chk("R6 toggled to B", int'(dispBank), 1);
    chk("R6 pending cleared", int'(swapPending), 0);
    checkFrame("R4 frame from B");
  endtask

  task automatic tWriteHidden();
    hostFill(0, N, 2);            // fills A while B shown
    checkFrame("R3 shown bank untouched");
    pulseReq();
    pulseReq();                   // R6 second request while pending
    checkFrame("R5 image held while pending");
    chk("R5 still B", int'(dispBank), 1);
    vblankPulse();
    chk("R6 one swap to A", int'(dispBank), 0);
    checkFrame("R2 frame from A");
    vblankPulse();
    chk("R8 idle vblank holds", int'(dispBank), 0);
  endtask

  task automatic tCoincident();
    hostFill(N/4, N/2, 3);        // partial update of B
    pulseReq();
    @(negedge clk);
    vblank = 1'b1; swapReq = 1'b1; // R7 request in the swap cycle
    modelSel = ~modelSel;
    @(negedge clk);
    swapReq = 1'b0;
    chk("R7 swapped to B", int'(dispBank), 1);
    chk("R7 request kept", int'(swapPending), 1);
    repeat (2) @(negedge clk);
    vblank = 1'b0;
    checkFrame("R4 partial frame B");
    vblankPulse();
    chk("R7 second swap to A", int'(dispBank), 0);
    chk("R7 pending cleared", int'(swapPending), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tFirstSwap();
    tWriteHidden();
    tCoincident();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule